// File: doc/BRIEF.md
# Selectable-Rate Periodic Tick Device

This peripheral sits on a processor I/O bus and produces periodic ticks at one of four rates chosen by software. Software writes a rate code with a data-out strobe. A start pulse arms the device and raises busy. The first tick after arming drops busy, raises done and, unless interrupts are masked, raises an interrupt request. A clear pulse drops both flags and halts the timer. Rate code 0 follows the power-line rate, which a static input sets to 60 or 50 ticks per second. Codes 1, 2 and 3 give 10, 100 and 1000 ticks per second.

The timer counts a timebase enable input whose rate is the `TB_HZ` parameter. One period is `TB_HZ / rate` enables. Once started, the timer reloads itself after every tick and keeps running across handshakes. A later start only re-arms busy and leaves the timer's phase alone. Only clear or reset halts it. Bus decode of the device code and the processor's interrupt priority chain are outside this block.

Top module: `rtc_ticker`

## Requirements
- R1: On a cycle with `dout_stb` high, the rate code is loaded from `dout_data[1:0]`, and all higher bits are ignored. The period in timebase enables is `TB_HZ/RATE1` for code 1, `TB_HZ/RATE2` for code 2 and `TB_HZ/RATE3` for code 3 (defaults 10, 100, 1000 ticks/s).
- R2: Code 0 uses `TB_HZ/LINE_HI` when `line_50` is 0 and `TB_HZ/LINE_LO` when `line_50` is 1 (defaults 60 and 50). The value of `line_50` is sampled each time the timer loads a period.
- R3: A start pulse makes busy 1 and done 0 on the next cycle. If the timer is halted, the start loads a full period, and the first tick comes on the period-th enabled edge after the start edge.
- R4: A start pulse while the timer runs does not change the timer's count or phase.
- R5: A clear pulse makes busy 0 and done 0 on the next cycle and halts the timer. A later start then begins a full new period.
- R6: A tick while busy is 1 makes busy 0 and done 1. A tick while busy is 0 changes no flag.
- R7: After each tick the timer reloads with the period of the rate code in effect at that edge, so a new code written while running applies from the following period.
- R8: While `rst` is high, busy, done and irq become 0, the rate code becomes 0 and the timer halts.
- R9: `irq` is a registered copy of (next done AND NOT `int_dis`). It is never 1 while done is 0.
- R10: Clear has priority over start, and start has priority over a tick for the flags. A start and a tick on the same edge leave busy 1 and done 0.
- R11: If a strobe and a start come on the same edge, the timer's first period uses the newly written code.
- R12: The counter advances only on edges where `tb_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_en | input | 1 | Timebase enable, one pulse per timebase period |
| dout_stb | input | 1 | Data-out strobe that writes the rate code |
| dout_data | input | DATA_W | Accumulator word; bits 1:0 hold the rate code |
| start_p | input | 1 | Start pulse |
| clear_p | input | 1 | Clear pulse |
| line_50 | input | 1 | Line rate select: 0 gives 60/s, 1 gives 50/s |
| int_dis | input | 1 | Interrupt disable mask bit |
| busy | output | 1 | Busy flag |
| done | output | 1 | Done flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `TB_HZ` = 2000, so the periods shrink to 33, 40, 200, 20 and 2 enables. At that size every rate code, both line rates, reloads at a changed code and a start that lands on a tick can all be reached within a few thousand cycles. The default 1 MHz build would need up to 100000 enables for one period. Directed cases pin the exact tick edge for each rate and ordering. A random phase with gapped enables then compares all three flags every cycle against a bench model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    SEL_LINE = 2'd0,
    SEL_SLOW = 2'd1,
    SEL_MID  = 2'd2,
    SEL_FAST = 2'd3
  } rate_sel_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rtc_rate_table.sv
module rtc_rate_table
  import rtc_pkg::*;
#(
  parameter int unsigned TB_HZ   = 1000000,
  parameter int unsigned LINE_HI = 60,
  parameter int unsigned LINE_LO = 50,
  parameter int unsigned RATE1   = 10,
  parameter int unsigned RATE2   = 100,
  parameter int unsigned RATE3   = 1000,
  parameter int unsigned CW      = 17
) (
  input  rate_sel_e        sel,
  input  logic             line_50,
  output logic [CW-1:0]    period
);
  localparam int unsigned NCODE = 4;

  function automatic int unsigned fixed_rate(input int unsigned code);
    case (code)
      1:       return RATE1;
      2:       return RATE2;
      default: return RATE3;
    endcase
  endfunction

  logic [CW-1:0] per_tab [NCODE];

  // code 0 follows the line-rate configuration
  assign per_tab[0] = line_50 ? CW'(TB_HZ / LINE_LO) : CW'(TB_HZ / LINE_HI);

  for (genvar g = 1; g < NCODE; g++) begin : g_fixed
    localparam int unsigned PER = TB_HZ / fixed_rate(g);
    assign per_tab[g] = CW'(PER);
  end

  assign period = per_tab[sel];
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer #(
  parameter int unsigned CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tb_en,
  input  logic          start,
  input  logic          clear,
  input  logic [CW-1:0] period,
  output logic          tick,
  output logic          running
);
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [CW-1:0] reload;

  assign reload  = period - CW'(1);
  assign tick    = run_q && tb_en && (cnt_q == '0);
  assign running = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (clear) begin
      run_q <= 1'b0;
    end else if (start && !run_q) begin
      run_q <= 1'b1;
      cnt_q <= reload;
    end else if (run_q && tb_en) begin
      if (cnt_q == '0) cnt_q <= reload;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic clear,
  input  logic tick,
  input  logic int_dis,
  output logic busy,
  output logic done,
  output logic irq
);
  logic busy_d, done_d;

  always_comb begin
    busy_d = busy;
    done_d = done;
    if (clear) begin
      busy_d = 1'b0;
      done_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      done_d = 1'b0;
    end else if (tick && busy) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      irq  <= 1'b0;
    end else begin
      busy <= busy_d;
      done <= done_d;
      irq  <= done_d && !int_dis;
    end
  end
endmodule

// File: rtl/rtc_ticker.sv
module rtc_ticker
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned TB_HZ   = 1000000,
  parameter int unsigned LINE_HI = 60,
  parameter int unsigned LINE_LO = 50,
  parameter int unsigned RATE1   = 10,
  parameter int unsigned RATE2   = 100,
  parameter int unsigned RATE3   = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tb_en,
  input  logic              dout_stb,
  input  logic [DATA_W-1:0] dout_data,
  input  logic              start_p,
  input  logic              clear_p,
  input  logic              line_50,
  input  logic              int_dis,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  localparam int unsigned MIN_RATE = (LINE_LO < RATE1) ? LINE_LO : RATE1;
  localparam int unsigned MAXP = max_u(max_u(TB_HZ / LINE_HI, TB_HZ / MIN_RATE),
                                       max_u(TB_HZ / RATE2, TB_HZ / RATE3));
  localparam int unsigned CW = $clog2(MAXP + 1);

  rate_sel_e     sel_q, sel_eff;
  logic [CW-1:0] period;
  logic          tick, running;
  logic          unused_upper;

  assign unused_upper = ^dout_data[DATA_W-1:2];
  assign sel_eff = dout_stb ? rate_sel_e'(dout_data[1:0]) : sel_q;

  always_ff @(posedge clk) begin
    if (rst)           sel_q <= SEL_LINE;
    else if (dout_stb) sel_q <= rate_sel_e'(dout_data[1:0]);
  end

  rtc_rate_table #(
    .TB_HZ(TB_HZ), .LINE_HI(LINE_HI), .LINE_LO(LINE_LO),
    .RATE1(RATE1), .RATE2(RATE2), .RATE3(RATE3), .CW(CW)
  ) u_tab (
    .sel(sel_eff), .line_50(line_50), .period(period)
  );

  rtc_tick_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .tb_en(tb_en), .start(start_p), .clear(clear_p),
    .period(period), .tick(tick), .running(running)
  );

  rtc_flags u_flg (
    .clk(clk), .rst(rst), .start(start_p), .clear(clear_p), .tick(tick),
    .int_dis(int_dis), .busy(busy), .done(done), .irq(irq)
  );
endmodule

// File: rtl/rtc_ticker_chk.sv
module rtc_ticker_chk (
  input logic clk,
  input logic rst,
  input logic start_p,
  input logic clear_p,
  input logic int_dis,
  input logic busy,
  input logic done,
  input logic irq
);
  assert_start_arms_R3: assert property (@(posedge clk) disable iff (rst)
    (start_p && !clear_p) |=> (busy && !done));

  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (rst)
    clear_p |=> (!busy && !done));

  assert_done_needs_busy_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (!busy && !done && !irq));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !int_dis && !start_p && !clear_p) |=> irq);

  assert_irq_needs_done_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> done);

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (clear_p && start_p) |=> !busy);
endmodule

bind rtc_ticker rtc_ticker_chk u_chk (
  .clk(clk), .rst(rst), .start_p(start_p), .clear_p(clear_p),
  .int_dis(int_dis), .busy(busy), .done(done), .irq(irq)
);

// File: tb/rtc_ticker_tb.sv
module rtc_ticker_tb;
  localparam int unsigned TBHZ = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tb_en = 1'b1, dout_stb = 1'b0, start_p = 1'b0, clear_p = 1'b0;
  logic line_50 = 1'b0, int_dis = 1'b0;
  logic [15:0] dout_data = '0;
  logic busy, done, irq;

  int n_chk = 0, n_fail = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  rtc_ticker #(.DATA_W(16), .TB_HZ(TBHZ)) u_dut (
    .clk(clk), .rst(rst), .tb_en(tb_en), .dout_stb(dout_stb), .dout_data(dout_data),
    .start_p(start_p), .clear_p(clear_p), .line_50(line_50), .int_dis(int_dis),
    .busy(busy), .done(done), .irq(irq)
  );

  function automatic int exp_period(input logic [1:0] code, input logic l50);
    case (code)
      2'd0:    return l50 ? TBHZ / 50 : TBHZ / 60;
      2'd1:    return TBHZ / 10;
      2'd2:    return TBHZ / 100;
      default: return TBHZ / 1000;
    endcase
  endfunction

  // bench reference model, written from the requirements
  logic [1:0] m_sel = 0;
  logic       m_run = 0, m_busy = 0, m_done = 0, m_irq = 0;
  int         m_cnt = 0;
  logic [1:0] es;
  logic       tk, nb, nd;
  always @(posedge clk) begin
    if (rst) begin
      m_sel <= 0; m_run <= 0; m_cnt <= 0; m_busy <= 0; m_done <= 0; m_irq <= 0;
    end else begin
      es = dout_stb ? dout_data[1:0] : m_sel;
      tk = m_run && tb_en && (m_cnt == 0);
      nb = m_busy; nd = m_done;
      if (clear_p) begin nb = 0; nd = 0; end
      else if (start_p) begin nb = 1; nd = 0; end
      else if (tk && m_busy) begin nb = 0; nd = 1; end
      m_sel <= es;
      if (clear_p) m_run <= 0;
      else if (start_p && !m_run) begin m_run <= 1; m_cnt <= exp_period(es, line_50) - 1; end
      else if (m_run && tb_en) m_cnt <= (m_cnt == 0) ? exp_period(es, line_50) - 1 : m_cnt - 1;
      m_busy <= nb; m_done <= nd; m_irq <= nd && !int_dis;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse(input logic s, input logic c, input logic w, input logic [15:0] d);
    start_p = s; clear_p = c; dout_stb = w; dout_data = d;
    step();
    start_p = 0; clear_p = 0; dout_stb = 0;
  endtask

  // edges after the last edge until done is seen; alt = enable only on even edges
  task automatic measure(input bit alt, output int k);
    k = 0;
    while (k < 2000) begin
      k++;
      tb_en = alt ? (k % 2 == 0) : 1'b1;
      step();
      if (done) break;
    end
    tb_en = 1;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'h1d2c));
    @(negedge clk); wait_n(3); rst = 0;
    check("R8 busy after reset", busy, 0);
    check("R8 done after reset", done, 0);
    check("R8 irq after reset", irq, 0);

    // R1: code 3 with garbage upper bits
    pulse(0, 0, 1, 16'hABC7);
    pulse(1, 0, 0, 0);
    check("R3 busy set", busy, 1);
    check("R3 done cleared", done, 0);
    measure(0, k); check("R1 code3 period", k, exp_period(3, 0));
    check("R9 irq with done", irq, 1);
    wait_n(20);
    check("R6 tick w/o busy keeps done", done, 1);
    check("R6 tick w/o busy keeps busy", busy, 0);
    int_dis = 1; step(); check("R9 masked irq", irq, 0);
    int_dis = 0; step(); check("R9 unmasked irq", irq, 1);

    // R5: clear halts timer
    pulse(0, 1, 1, 16'h0002);
    check("R5 busy cleared", busy, 0);
    check("R5 done cleared", done, 0);
    check("R9 irq cleared", irq, 0);
    pulse(1, 0, 0, 0); wait_n(7);
    pulse(0, 1, 0, 0); wait_n(5);
    pulse(1, 0, 0, 0);
    measure(0, k); check("R5 full period after clear", k, exp_period(2, 0));

    pulse(0, 1, 1, 16'h0001); pulse(1, 0, 0, 0);
    measure(0, k); check("R1 code1 period", k, exp_period(1, 0));
    pulse(0, 1, 1, 16'h0000); pulse(1, 0, 0, 0);
    measure(0, k); check("R2 line 60 period", k, exp_period(0, 0));
    line_50 = 1;
    pulse(0, 1, 0, 0); pulse(1, 0, 0, 0);
    measure(0, k); check("R2 line 50 period", k, exp_period(0, 1));
    line_50 = 0;

    // R12: gated enables
    pulse(0, 1, 1, 16'h0002); pulse(1, 0, 0, 0);
    measure(1, k); check("R12 alternating enables", k, 2 * exp_period(2, 0));
    pulse(1, 0, 0, 0); tb_en = 0; wait_n(100);
    check("R12 no tick without enable", done, 0);
    tb_en = 1;

    // R4: restart while running keeps phase
    pulse(0, 1, 0, 0); pulse(1, 0, 0, 0); wait_n(7); pulse(1, 0, 0, 0);
    measure(0, k); check("R4 phase kept", k, exp_period(2, 0) - 8);

    // R10: clear+start together
    pulse(1, 1, 0, 0);
    check("R10 clear beats start busy", busy, 0);
    wait_n(60); check("R10 timer halted", done, 0);
    // R10: start on the tick edge
    pulse(0, 0, 1, 16'h0003); pulse(1, 0, 0, 0);
    measure(0, k); check("R1 code3 again", k, 2);
    step(); pulse(1, 0, 0, 0);
    check("R10 start beats tick busy", busy, 1);
    check("R10 start beats tick done", done, 0);
    measure(0, k); check("R10 next tick", k, 2);

    // R11: strobe and start together
    pulse(0, 1, 0, 0); pulse(1, 0, 1, 16'hFF02);
    measure(0, k); check("R11 new code used", k, exp_period(2, 0));

    // R7: code change while running applies next period
    pulse(0, 1, 0, 0); pulse(1, 0, 1, 16'h0002);
    measure(0, k); check("R7 first period", k, exp_period(2, 0));
    pulse(0, 0, 1, 16'h0003); pulse(1, 0, 0, 0);
    measure(0, k); check("R7 remainder of old period", k, exp_period(2, 0) - 2);
    pulse(1, 0, 0, 0);
    measure(0, k); check("R7 new period in effect", k, exp_period(3, 0) - 1);

    // R8: reset mid-run restores code 0
    pulse(0, 0, 1, 16'h0001); pulse(1, 0, 0, 0); wait_n(5);
    rst = 1; step(); rst = 0;
    check("R8 busy after mid reset", busy, 0);
    wait_n(300); check("R8 timer halted", done, 0);
    pulse(1, 0, 0, 0);
    measure(0, k); check("R8 code back to 0", k, exp_period(0, 0));

    // random phase against the model
    for (int c = 0; c < 5000; c++) begin
      tb_en    = ($urandom % 4) != 0;
      start_p  = ($urandom % 40) == 0;
      clear_p  = ($urandom % 150) == 0;
      dout_stb = ($urandom % 60) == 0;
      dout_data = 16'($urandom);
      if (($urandom % 50) == 0) int_dis = ~int_dis;
      if (($urandom % 300) == 0) line_50 = ~line_50;
      step();
      check("R6 model done", done, m_done);
      check("R3 model busy", busy, m_busy);
      check("R9 model irq", irq, m_irq);
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    end
    $finish;
  end
endmodule